// File: doc/BRIEF.md
# Endian Lane Steering Unit

This unit sits between a 32-bit processor load/store port and a little-endian memory bus. Each request carries a byte address, an access size (byte, halfword or word), write data, a write flag and a flag marking an instruction fetch. The unit turns the request into a bus address, byte-lane strobes and lane-aligned write data. When read data comes back, it reorders the lanes and returns the value right-justified in the low-order bits.

Data accesses follow one of three byte orders. In plain little-endian order, lanes follow addresses directly. In byte-invariant big-endian order, the bytes of a value are reversed so that its most significant byte lands at the lowest address, and the address is not changed. In word-invariant big-endian order, a word travels unchanged. A byte or halfword instead has its address steered to the mirrored position inside the word, and its bytes are never reordered.

The order in force is loaded from a configuration input while reset is held, and software can rewrite it later. Instruction fetches always use little-endian order. All bus-side and response outputs are registered.

Top module: `endian_lane_steer`

## Requirements
- R1: While `rst` is high, the order register loads `cfg_boot_mode` (0 = little-endian, 1 = byte-invariant big-endian, 2 = word-invariant big-endian, 3 = little-endian). The cycle after reset, `bus_valid`, `bus_err`, `rsp_valid` and `bus_strb` are all zero.
- R2: In little-endian order, the bus address equals the request address. Byte k of the request data (bits 8k+7:8k) goes to lane (address[1:0] + k).
- R3: In byte-invariant order, the bus address equals the request address. Byte k of an N-byte access goes to lane (address[1:0] + N-1-k), so the most significant byte sits at the lowest address. A read reverses the lanes back in the same way.
- R4: In word-invariant order, a word access has the same bus address, strobes and data lanes as in little-endian order.
- R5: In word-invariant order, a byte access drives bus address bits 1:0 as address[1:0] XOR 3. A halfword access inverts address bit 1. Data bytes keep little-endian lane order from the new address, so byte address 0 travels on lines 31:24.
- R6: An access is rejected in any of three cases: size code 3, an access that would run past the end of the 4-byte word, or any misaligned access in word-invariant order. A rejected access raises `bus_err` for one cycle and leaves `bus_valid` low and `bus_strb` zero.
- R7: A request with `req_instr` high is mapped in little-endian order whatever order is set.
- R8: `bus_strb` has one bit set for each byte of the access, starting at the final bus address offset. Read data comes back zero-extended in the low N bytes. `bus_wdata` is zero for reads.
- R9: A write to the order register takes effect from the next request. A request presented in the same cycle as the write uses the old order. A read already issued is steered with the order it was issued under.
- R10: Bus outputs appear one cycle after `req_valid`. `rsp_valid` and `rsp_rdata` appear one cycle after `bus_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_boot_mode | input | 2 | Byte order loaded during reset |
| mode_wr_en | input | 1 | Run-time order register write strobe |
| mode_wr_val | input | 2 | Run-time order value |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | Request is a store |
| req_instr | input | 1 | Request is an instruction fetch |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| req_addr | input | ADDR_W | Request byte address |
| req_wdata | input | DATA_W | Store data, right-justified |
| bus_valid | output | 1 | Bus access issued |
| bus_write | output | 1 | Bus access is a write |
| bus_err | output | 1 | Request rejected |
| bus_addr | output | ADDR_W | Steered bus byte address |
| bus_strb | output | DATA_W/8 | Byte-lane strobes |
| bus_wdata | output | DATA_W | Lane-aligned store data |
| bus_rvalid | input | 1 | Read data returned from bus |
| bus_rdata | input | DATA_W | Bus read data |
| rsp_valid | output | 1 | Load result valid |
| rsp_rdata | output | DATA_W | Load result, right-justified |

## Verification
The bench builds the unit with its defaults: a 32-bit address and a 32-bit data path with four lanes. This covers every size and offset pair for all three orders, including the reserved size code and the word-boundary overrun cases. Random accesses are mixed with order rewrites, some placed in the same cycle as a request and some placed while a read is still outstanding. These exercise the timing of order changes against the issue-time order.

// File: rtl/endian_pkg.sv
package endian_pkg;

  typedef enum logic [1:0] {
    ORD_LE = 2'd0,
    ORD_BI = 2'd1,
    ORD_WI = 2'd2
  } byte_order_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  function automatic byte_order_e order_decode(input logic [1:0] raw);
    case (raw)
      2'd1:    order_decode = ORD_BI;
      2'd2:    order_decode = ORD_WI;
      default: order_decode = ORD_LE;
    endcase
  endfunction

endpackage

// File: rtl/endian_order_reg.sv
module endian_order_reg
  import endian_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  boot_val,
  input  logic        wr_en,
  input  logic [1:0]  wr_val,
  output byte_order_e order
);

  always_ff @(posedge clk) begin
    if (rst) begin
      order <= order_decode(boot_val);
    end else if (wr_en) begin
      order <= order_decode(wr_val);
    end
  end

endmodule

// File: rtl/endian_req_map.sv
module endian_req_map
  import endian_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LANES  = 4,
  parameter int OFF_W  = 2
) (
  input  byte_order_e          order,
  input  logic                 instr,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [1:0]           size,
  input  logic [LANES*8-1:0]   wdata,
  output byte_order_e          eff_order,
  output logic                 err,
  output logic [OFF_W-1:0]     bus_off,
  output logic [ADDR_W-1:0]    bus_addr,
  output logic [LANES-1:0]     strb,
  output logic [LANES*8-1:0]   lane_data
);

  logic [LANES*8-1:0] ordered;
  int nbytes;
  int offset;
  int boff;

  always_comb begin
    eff_order = instr ? ORD_LE : order;
    nbytes    = 1 << size;
    offset    = int'(addr[OFF_W-1:0]);
    err       = (nbytes > LANES) || (offset + nbytes > LANES) ||
                ((eff_order == ORD_WI) && ((offset % nbytes) != 0));
    if (!err && eff_order == ORD_WI) begin
      boff = offset ^ (LANES - nbytes);
    end else begin
      boff = offset;
    end

    ordered = '0;
    for (int i = 0; i < LANES; i++) begin
      if (i < nbytes) begin
        if (eff_order == ORD_BI) begin
          ordered[i*8 +: 8] = wdata[(nbytes-1-i)*8 +: 8];
        end else begin
          ordered[i*8 +: 8] = wdata[i*8 +: 8];
        end
      end
    end

    strb      = '0;
    lane_data = '0;
    for (int i = 0; i < LANES; i++) begin
      if (!err && i >= boff && i < boff + nbytes) begin
        strb[i]           = 1'b1;
        lane_data[i*8 +: 8] = ordered[(i-boff)*8 +: 8];
      end
    end

    bus_off  = OFF_W'(boff);
    bus_addr = {addr[ADDR_W-1:OFF_W], OFF_W'(boff)};
  end

endmodule

// File: rtl/endian_rd_steer.sv
module endian_rd_steer
  import endian_pkg::*;
#(
  parameter int LANES = 4,
  parameter int OFF_W = 2
) (
  input  byte_order_e        order,
  input  logic [1:0]         size,
  input  logic [OFF_W-1:0]   off,
  input  logic [LANES*8-1:0] rdata,
  output logic [LANES*8-1:0] data
);

  int nbytes;
  int src;

  always_comb begin
    nbytes = 1 << size;
    if (nbytes > LANES) begin
      nbytes = LANES;
    end
    data = '0;
    src  = 0;
    for (int i = 0; i < LANES; i++) begin
      if (i < nbytes) begin
        if (order == ORD_BI) begin
          src = int'(off) + nbytes - 1 - i;
        end else begin
          src = int'(off) + i;
        end
        if (src < LANES) begin
          data[i*8 +: 8] = rdata[src*8 +: 8];
        end
      end
    end
  end

endmodule

// File: rtl/endian_lane_steer.sv
module endian_lane_steer
  import endian_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          cfg_boot_mode,
  input  logic                mode_wr_en,
  input  logic [1:0]          mode_wr_val,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic                req_instr,
  input  logic [1:0]          req_size,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                bus_valid,
  output logic                bus_write,
  output logic                bus_err,
  output logic [ADDR_W-1:0]   bus_addr,
  output logic [DATA_W/8-1:0] bus_strb,
  output logic [DATA_W-1:0]   bus_wdata,
  input  logic                bus_rvalid,
  input  logic [DATA_W-1:0]   bus_rdata,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_rdata
);

  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANES);

  byte_order_e        cur_order;
  byte_order_e        map_order;
  logic               map_err;
  logic [OFF_W-1:0]   map_off;
  logic [ADDR_W-1:0]  map_addr;
  logic [LANES-1:0]   map_strb;
  logic [DATA_W-1:0]  map_data;

  byte_order_e        pend_order;
  logic [1:0]         pend_size;
  logic [OFF_W-1:0]   pend_off;
  logic [DATA_W-1:0]  steer_data;

  endian_order_reg u_order (
    .clk      (clk),
    .rst      (rst),
    .boot_val (cfg_boot_mode),
    .wr_en    (mode_wr_en),
    .wr_val   (mode_wr_val),
    .order    (cur_order)
  );

  endian_req_map #(
    .ADDR_W (ADDR_W),
    .LANES  (LANES),
    .OFF_W  (OFF_W)
  ) u_map (
    .order     (cur_order),
    .instr     (req_instr),
    .addr      (req_addr),
    .size      (req_size),
    .wdata     (req_wdata),
    .eff_order (map_order),
    .err       (map_err),
    .bus_off   (map_off),
    .bus_addr  (map_addr),
    .strb      (map_strb),
    .lane_data (map_data)
  );

  endian_rd_steer #(
    .LANES (LANES),
    .OFF_W (OFF_W)
  ) u_rd (
    .order (pend_order),
    .size  (pend_size),
    .off   (pend_off),
    .rdata (bus_rdata),
    .data  (steer_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_valid  <= 1'b0;
      bus_write  <= 1'b0;
      bus_err    <= 1'b0;
      bus_addr   <= '0;
      bus_strb   <= '0;
      bus_wdata  <= '0;
      pend_order <= ORD_LE;
      pend_size  <= 2'd0;
      pend_off   <= '0;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
    end else begin
      bus_valid <= req_valid && !map_err;
      bus_err   <= req_valid && map_err;
      bus_strb  <= req_valid ? map_strb : '0;
      if (req_valid) begin
        bus_addr  <= map_addr;
        bus_write <= req_write;
        bus_wdata <= req_write ? map_data : '0;
      end
      if (req_valid && !req_write && !map_err) begin
        pend_order <= map_order;
        pend_size  <= req_size;
        pend_off   <= map_off;
      end
      rsp_valid <= bus_rvalid;
      if (bus_rvalid) begin
        rsp_rdata <= steer_data;
      end
    end
  end

endmodule

// File: rtl/endian_lane_steer_chk.sv
module endian_lane_steer_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                req_valid,
  input logic                req_instr,
  input logic [1:0]          req_size,
  input logic [ADDR_W-1:0]   req_addr,
  input logic                bus_valid,
  input logic                bus_err,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [DATA_W/8-1:0] bus_strb,
  input logic                bus_rvalid,
  input logic                rsp_valid
);

  a_r1_quiet_after_reset: assert property (@(posedge clk)
    rst |=> (!bus_valid && !bus_err && !rsp_valid && bus_strb == '0));

  a_r6_reject_no_strobe: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> (!bus_valid && bus_strb == '0));

  a_r8_strobe_count: assert property (@(posedge clk) disable iff (rst)
    bus_valid |-> ($countones(bus_strb) == (1 << $past(req_size))));

  a_r7_fetch_addr_kept: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && $past(req_instr)) |-> (bus_addr == $past(req_addr)));

  a_r4_word_addr_kept: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && $past(req_size) == 2'd2) |-> (bus_addr == $past(req_addr)));

  a_r10_bus_after_req: assert property (@(posedge clk) disable iff (rst)
    (bus_valid || bus_err) |-> $past(req_valid));

  a_r10_rsp_after_bus: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(bus_rvalid));

endmodule

bind endian_lane_steer endian_lane_steer_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_instr  (req_instr),
  .req_size   (req_size),
  .req_addr   (req_addr),
  .bus_valid  (bus_valid),
  .bus_err    (bus_err),
  .bus_addr   (bus_addr),
  .bus_strb   (bus_strb),
  .bus_rvalid (bus_rvalid),
  .rsp_valid  (rsp_valid)
);

// File: tb/endian_lane_steer_tb.sv
`timescale 1ns/1ps
module endian_lane_steer_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  cfg_boot_mode = 2'd0;
  logic        mode_wr_en = 1'b0;
  logic [1:0]  mode_wr_val = 2'd0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic        req_instr = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [31:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        bus_valid;
  logic        bus_write;
  logic        bus_err;
  logic [31:0] bus_addr;
  logic [3:0]  bus_strb;
  logic [31:0] bus_wdata;
  logic        bus_rvalid = 1'b0;
  logic [31:0] bus_rdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;

  int checks = 0;
  int errors = 0;
  int tb_order = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  endian_lane_steer u_dut (
    .clk (clk), .rst (rst), .cfg_boot_mode (cfg_boot_mode),
    .mode_wr_en (mode_wr_en), .mode_wr_val (mode_wr_val),
    .req_valid (req_valid), .req_write (req_write), .req_instr (req_instr),
    .req_size (req_size), .req_addr (req_addr), .req_wdata (req_wdata),
    .bus_valid (bus_valid), .bus_write (bus_write), .bus_err (bus_err),
    .bus_addr (bus_addr), .bus_strb (bus_strb), .bus_wdata (bus_wdata),
    .bus_rvalid (bus_rvalid), .bus_rdata (bus_rdata),
    .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata)
  );

  function automatic int decode(input logic [1:0] v);
    return (v == 2'd1) ? 1 : (v == 2'd2) ? 2 : 0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference model: lanes counted from the steered offset, bytes picked by order.
  function automatic void model(input int ord, input bit ins, input logic [31:0] a,
                                input logic [1:0] sz, input logic [31:0] wd,
                                input logic [31:0] rb, output bit err,
                                output logic [31:0] ba, output logic [3:0] st,
                                output logic [31:0] bw, output logic [31:0] rr);
    int m;
    int nb;
    int off;
    int bo;
    m   = ins ? 0 : ord;
    nb  = 1 << sz;
    off = int'(a[1:0]);
    err = (sz == 2'd3) || (off + nb > 4) || (m == 2 && (off % nb) != 0);
    bo  = off;
    if (!err && m == 2) bo = 4 - nb - off;
    ba = {a[31:2], 2'(bo)};
    st = '0; bw = '0; rr = '0;
    if (!err) begin
      for (int k = 0; k < nb; k++) begin
        int lane;
        int sb;
        lane = bo + k;
        sb   = (m == 1) ? (nb - 1 - k) : k;
        st[lane] = 1'b1;
        bw[lane*8 +: 8] = wd[sb*8 +: 8];
        rr[sb*8 +: 8]   = rb[lane*8 +: 8];
      end
    end
  endfunction

  task automatic do_reset(input logic [1:0] boot);
    @(negedge clk);
    rst = 1'b1;
    cfg_boot_mode = boot;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tb_order = decode(boot);
    #1;
    chk("R1 bus_valid after reset", 32'(bus_valid), 32'd0);
    chk("R1 bus_err after reset", 32'(bus_err), 32'd0);
    chk("R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
    chk("R1 bus_strb after reset", 32'(bus_strb), 32'd0);
  endtask

  // One request; optional order write in the same cycle, optional write while a read is outstanding.
  task automatic access(input string tag, input logic [31:0] a, input logic [1:0] sz,
                        input logic [31:0] wd, input bit wr, input bit ins,
                        input logic [31:0] rb, input bit same_wr, input logic [1:0] same_val,
                        input bit mid_wr, input logic [1:0] mid_val);
    bit e;
    logic [31:0] ba;
    logic [3:0]  st;
    logic [31:0] bw;
    logic [31:0] rr;
    model(tb_order, ins, a, sz, wd, rb, e, ba, st, bw, rr);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_size = sz; req_wdata = wd;
    req_write = wr; req_instr = ins;
    mode_wr_en = same_wr; mode_wr_val = same_val;
    @(posedge clk);
    #1;
    req_valid = 1'b0; mode_wr_en = 1'b0;
    if (same_wr) tb_order = decode(same_val);
    chk({tag, " R10/R6 bus_valid"}, 32'(bus_valid), 32'(!e));
    chk({tag, " R6 bus_err"}, 32'(bus_err), 32'(e));
    chk({tag, " R8 bus_strb"}, 32'(bus_strb), 32'(st));
    if (!e) begin
      chk({tag, " bus_addr"}, bus_addr, ba);
      chk({tag, " R8 bus_wdata"}, bus_wdata, wr ? bw : 32'd0);
      chk({tag, " bus_write"}, 32'(bus_write), 32'(wr));
    end
    if (!e && !wr) begin
      @(negedge clk);
      bus_rvalid = 1'b1; bus_rdata = rb;
      mode_wr_en = mid_wr; mode_wr_val = mid_val;
      @(posedge clk);
      #1;
      bus_rvalid = 1'b0; mode_wr_en = 1'b0;
      if (mid_wr) tb_order = decode(mid_val);
      chk({tag, " R10 rsp_valid"}, 32'(rsp_valid), 32'd1);
      chk({tag, " R8 rsp_rdata"}, rsp_rdata, rr);
    end
  endtask

  initial begin
    #(5ns * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1: boot into byte-invariant big-endian
    do_reset(2'd1);
    // R3: word store reversed, halfword reversed, word load reversed back
    access("R3 word store", 32'h100, 2'd2, 32'h11223344, 1, 0, 0, 0, 0, 0, 0);
    chk("R3 word lanes", bus_wdata, 32'h44332211);
    access("R3 half store", 32'h102, 2'd1, 32'h0000AABB, 1, 0, 0, 0, 0, 0, 0);
    chk("R3 half lanes", bus_wdata, 32'hBBAA0000);
    access("R3 word load", 32'h200, 2'd2, 0, 0, 0, 32'h44332211, 0, 0, 0, 0);
    chk("R3 load value", rsp_rdata, 32'h11223344);
    // R9: order write in the same cycle uses the old order for that request
    access("R9 same-cycle", 32'h300, 2'd2, 32'hA1B2C3D4, 1, 0, 0, 1, 2'd2, 0, 0);
    chk("R9 old order used", bus_wdata, 32'hD4C3B2A1);
    // R5: word-invariant sub-word steering
    access("R5 byte store", 32'h100, 2'd0, 32'h0000005A, 1, 0, 0, 0, 0, 0, 0);
    chk("R5 byte addr", bus_addr, 32'h103);
    chk("R5 byte lane 31:24", bus_wdata, 32'h5A000000);
    access("R5 half load", 32'h102, 2'd1, 0, 0, 0, 32'h0000CDEF, 0, 0, 0, 0);
    chk("R5 half addr", bus_addr, 32'h100);
    chk("R5 half value", rsp_rdata, 32'h0000CDEF);
    // R4: word unchanged
    access("R4 word store", 32'h104, 2'd2, 32'h01020304, 1, 0, 0, 0, 0, 0, 0);
    chk("R4 word lanes", bus_wdata, 32'h01020304);
    // R6: rejects
    access("R6 WI misaligned half", 32'h101, 2'd1, 0, 1, 0, 0, 0, 0, 0, 0);
    access("R6 reserved size", 32'h100, 2'd3, 0, 0, 0, 0, 0, 0, 0, 0);
    // R7: fetch in word-invariant order stays little-endian
    access("R7 fetch byte", 32'h101, 2'd0, 0, 0, 1, 32'h0000AB00, 0, 0, 0, 0);
    chk("R7 fetch addr", bus_addr, 32'h101);
    chk("R7 fetch value", rsp_rdata, 32'h000000AB);
    // R9: in-flight read keeps byte-invariant order after switch to LE
    access("R9 set BI", 32'h0, 2'd2, 0, 1, 0, 0, 1, 2'd1, 0, 0);
    access("R9 inflight", 32'h10, 2'd2, 0, 0, 0, 32'h78563412, 0, 0, 1, 2'd0);
    chk("R9 inflight value", rsp_rdata, 32'h12345678);
    // R2: little-endian order now in force
    access("R2 half store", 32'h21, 2'd1, 32'h0000BEEF, 1, 0, 0, 0, 0, 0, 0);
    chk("R2 half lanes", bus_wdata, 32'h00BEEF00);
    access("R6 LE overrun", 32'h22, 2'd2, 0, 1, 0, 0, 0, 0, 0, 0);
    // random mix
    for (int n = 0; n < 600; n++) begin
      logic [31:0] a;
      logic [1:0]  sz;
      bit sw;
      bit mw;
      a  = $urandom();
      sz = 2'($urandom_range(0, 3));
      sw = ($urandom_range(0, 7) == 0);
      mw = ($urandom_range(0, 5) == 0);
      access("RND", a, sz, $urandom(), 1'($urandom_range(0, 1)),
             ($urandom_range(0, 9) == 0), $urandom(), sw,
             2'($urandom_range(0, 3)), mw, 2'($urandom_range(0, 3)));
    end
    // R1: boot value 3 selects little-endian
    do_reset(2'd3);
    access("R1 boot3 word", 32'h40, 2'd2, 32'hCAFE0123, 1, 0, 0, 0, 0, 0, 0);
    chk("R1 boot3 lanes", bus_wdata, 32'hCAFE0123);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule